// File: doc/BRIEF.md
# Bus Cycle Wait-State Inserter

This block sequences one external bus access through four bus states and can lengthen the access for slow devices. It does this by inserting extra states between the third and the fourth bus state. Software picks the number of extra states with a two-bit selector: none, four, eight or twelve. The block runs from a clock at twice the CPU rate, so every bus state and every inserted state lasts exactly one half of a CPU clock cycle.

Waits apply only when the access goes to an external target and the CPU is running from its fast clock. If the access targets an internal register or internal memory, the bus cycle always has four states. The same holds while the CPU runs from its low-speed oscillator. As a result, the selector has no effect when the chip works with no external bus. The selector and both qualifying flags are captured once, in the first state of a cycle. A write to the selector during a cycle therefore changes only the cycles that follow. Address decoding and data movement are handled elsewhere. Other logic uses the state code, the wait-active flag and the done pulse to drive and hold the bus strobes.

Top module: `bus_wait_inserter`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it is asserted (including in the middle of a cycle), `state_o` is 0 (idle) and `wait_active_o` and `cyc_done_o` are low.
- R2: A high `cyc_start_i` in the idle state begins a cycle. The cycle then moves through T1, T2 and T3, then the inserted states, then T4, one state per clock. A cycle lasts exactly 4 plus the wait count in clocks. `cyc_start_i` is ignored in T1, T2, T3 and the wait states.
- R3: The selector `wait_sel_i` encodes the wait count: 2'b00 gives 0 inserted states, 2'b01 gives 4, 2'b10 gives 8 and 2'b11 gives 12.
- R4: Inserted states only ever come between T3 and T4. `wait_active_o` is high in exactly those states and low in every other state.
- R5: If `ext_access_i` is low when sampled in T1, the access is internal. No states are inserted, whatever the selector says.
- R6: If `slow_clk_i` is high when sampled in T1, no states are inserted, whatever the selector says.
- R7: The selector, `ext_access_i` and `slow_clk_i` are sampled in T1 only. Changes after T1 have no effect on the cycle in progress.
- R8: `cyc_done_o` is high for exactly one clock, during T4. If `cyc_start_i` is high in T4, the next state is T1 with no idle clock between cycles. Otherwise the next state is idle.
- R9: The values of `state_o` are: 0 = idle, 1 = T1, 2 = T2, 3 = T3, 4 = inserted wait state, 5 = T4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; one period is one bus state |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start_i | input | 1 | Request to begin a bus cycle |
| ext_access_i | input | 1 | High when the access targets an external device |
| slow_clk_i | input | 1 | High while the CPU runs from the low-speed oscillator |
| wait_sel_i | input | 2 | Wait count selector (00/01/10/11 → 0/4/8/12 states) |
| state_o | output | 3 | Current bus state code |
| wait_active_o | output | 1 | High during inserted wait states |
| cyc_done_o | output | 1 | One-clock pulse during T4 |

## Verification
The bench runs every selector value. It checks the count of inserted states and the total cycle length, so a decoder that swaps codes or scales by the wrong step gives the wrong count. Internal accesses and slow-clock accesses are run with the largest selector value, which exposes a design that ignores either qualifier. Some cycles flip the selector and the external flag right after T1; a design that reads them live instead of holding them grows or shrinks the wait stretch. Back-to-back requests and a reset in the middle of a wait stretch check that a design neither drops a T1 nor leaves a stale count behind.

// File: rtl/bwi_pkg.sv
package bwi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_T3   = 3'd3,
        ST_WAIT = 3'd4,
        ST_T4   = 3'd5
    } bus_state_e;

    typedef struct packed {
        bus_state_e st;
        logic       wait_act;
        logic       done;
    } fsm_regs_s;

endpackage

// File: rtl/bwi_wait_decode.sv
module bwi_wait_decode #(
    parameter int SEL_W     = 2,
    parameter int WAIT_STEP = 4,
    parameter int CNT_W     = 4
) (
    input  logic [SEL_W-1:0] sel_i,
    input  logic             ext_i,
    input  logic             slow_i,
    output logic [CNT_W-1:0] count_o
);

    logic qualify;

    always_comb begin
        qualify = ext_i && !slow_i;
        if (qualify) begin
            count_o = CNT_W'(sel_i) * CNT_W'(WAIT_STEP);
        end else begin
            count_o = '0;
        end
    end

endmodule

// File: rtl/bwi_wait_ctr.sv
module bwi_wait_ctr #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (dec_i && cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/bus_wait_inserter.sv
module bus_wait_inserter
    import bwi_pkg::*;
#(
    parameter int SEL_W     = 2,
    parameter int WAIT_STEP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_start_i,
    input  logic             ext_access_i,
    input  logic             slow_clk_i,
    input  logic [SEL_W-1:0] wait_sel_i,
    output logic [2:0]       state_o,
    output logic             wait_active_o,
    output logic             cyc_done_o
);

    localparam int MAX_WAITS = WAIT_STEP * ((1 << SEL_W) - 1);
    localparam int CNT_W     = $clog2(MAX_WAITS + 1);

    fsm_regs_s        regs_d, regs_q;
    logic [CNT_W-1:0] dec_count;
    logic [CNT_W-1:0] wait_cnt;
    logic             ctr_load;
    logic             ctr_dec;

    bwi_wait_decode #(
        .SEL_W     (SEL_W),
        .WAIT_STEP (WAIT_STEP),
        .CNT_W     (CNT_W)
    ) decode_i (
        .sel_i   (wait_sel_i),
        .ext_i   (ext_access_i),
        .slow_i  (slow_clk_i),
        .count_o (dec_count)
    );

    bwi_wait_ctr #(
        .CNT_W (CNT_W)
    ) ctr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (ctr_load),
        .load_val_i (dec_count),
        .dec_i      (ctr_dec),
        .cnt_o      (wait_cnt)
    );

    always_comb begin
        regs_d   = regs_q;
        ctr_load = 1'b0;
        ctr_dec  = 1'b0;
        unique case (regs_q.st)
            ST_IDLE: begin
                if (cyc_start_i) regs_d.st = ST_T1;
            end
            ST_T1: begin
                ctr_load  = 1'b1;
                regs_d.st = ST_T2;
            end
            ST_T2: begin
                regs_d.st = ST_T3;
            end
            ST_T3: begin
                regs_d.st = (wait_cnt != '0) ? ST_WAIT : ST_T4;
            end
            ST_WAIT: begin
                ctr_dec   = 1'b1;
                regs_d.st = (wait_cnt == CNT_W'(1)) ? ST_T4 : ST_WAIT;
            end
            ST_T4: begin
                regs_d.st = cyc_start_i ? ST_T1 : ST_IDLE;
            end
            default: begin
                regs_d.st = ST_IDLE;
            end
        endcase
        regs_d.wait_act = (regs_d.st == ST_WAIT);
        regs_d.done     = (regs_d.st == ST_T4);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{st: ST_IDLE, wait_act: 1'b0, done: 1'b0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign state_o       = regs_q.st;
    assign wait_active_o = regs_q.wait_act;
    assign cyc_done_o    = regs_q.done;

endmodule

// File: rtl/bwi_checker.sv
module bwi_checker #(
    parameter int SEL_W     = 2,
    parameter int WAIT_STEP = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cyc_start_i,
    input logic             ext_access_i,
    input logic             slow_clk_i,
    input logic [SEL_W-1:0] wait_sel_i,
    input logic [2:0]       state_o,
    input logic             wait_active_o,
    input logic             cyc_done_o
);

    localparam int MAX_WAITS = WAIT_STEP * ((1 << SEL_W) - 1);

    logic [7:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (state_o == 3'd4) begin
            run_q <= run_q + 8'd1;
        end else begin
            run_q <= '0;
        end
    end

    AST_T1_TO_T2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd1) |=> (state_o == 3'd2)); // R2
    AST_T2_TO_T3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd2) |=> (state_o == 3'd3)); // R2
    AST_T3_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd3) |=> (state_o == 3'd4 || state_o == 3'd5)); // R4
    AST_WAIT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd4) |=> (state_o == 3'd4 || state_o == 3'd5)); // R4
    AST_WAIT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        wait_active_o |-> (state_o == 3'd4)); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done_o |=> !cyc_done_o); // R8
    AST_NO_WAIT_UNQUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd1 && (!ext_access_i || slow_clk_i)) |-> ##3 (state_o == 3'd5)); // R5
    AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= 8'(MAX_WAITS)); // R3
    AST_START_AFTER_T4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd5 && cyc_start_i) |=> (state_o == 3'd1)); // R8

endmodule

bind bus_wait_inserter bwi_checker #(
    .SEL_W     (SEL_W),
    .WAIT_STEP (WAIT_STEP)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cyc_start_i   (cyc_start_i),
    .ext_access_i  (ext_access_i),
    .slow_clk_i    (slow_clk_i),
    .wait_sel_i    (wait_sel_i),
    .state_o       (state_o),
    .wait_active_o (wait_active_o),
    .cyc_done_o    (cyc_done_o)
);

// File: tb/bus_wait_inserter_tb.sv
`timescale 1ns/1ps
module bus_wait_inserter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_start = 1'b0;
    logic       ext_acc = 1'b1;
    logic       slow_clk = 1'b0;
    logic [1:0] wait_sel = 2'b00;
    logic [2:0] state;
    logic       wait_act;
    logic       done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    int m_state = 0;
    int m_wait  = 0;

    always #2.5 clk = ~clk;

    bus_wait_inserter dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cyc_start_i   (cyc_start),
        .ext_access_i  (ext_acc),
        .slow_clk_i    (slow_clk),
        .wait_sel_i    (wait_sel),
        .state_o       (state),
        .wait_active_o (wait_act),
        .cyc_done_o    (done)
    );

    // Behavioural reference: one state per rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0;
            m_wait  = 0;
        end else begin
            case (m_state)
                0: if (cyc_start) m_state = 1;
                1: begin
                    m_wait  = (ext_acc && !slow_clk) ? 4 * int'(wait_sel) : 0;
                    m_state = 2;
                end
                2: m_state = 3;
                3: m_state = (m_wait > 0) ? 4 : 5;
                4: begin
                    m_wait  = m_wait - 1;
                    m_state = (m_wait == 0) ? 5 : 4;
                end
                5: m_state = cyc_start ? 1 : 0;
                default: m_state = 0;
            endcase
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        check("R9 state code", int'(state), m_state);
        check("R4 wait_active", int'(wait_act), int'(m_state == 4));
        check("R8 done pulse", int'(done), int'(m_state == 5));
    endtask

    task automatic run_cycle(input logic [1:0] sel, input logic ext_v, input logic slow_v,
                             input int exp_w, input bit change_mid, input bit hold_start,
                             input string tag);
        int nw = 0;
        int ns = 0;
        cyc_start = 1'b1;
        wait_sel  = sel;
        ext_acc   = ext_v;
        slow_clk  = slow_v;
        step();
        check({tag, " enters T1"}, int'(state), 1);
        cyc_start = hold_start;
        for (int i = 0; i < 40; i++) begin
            if (state != 3'd0) ns++;
            if (state == 3'd4) nw++;
            if (done) break;
            step();
            if (i == 0 && change_mid) begin
                wait_sel = ~sel;
                ext_acc  = ~ext_v;
                slow_clk = ~slow_v;
            end
        end
        check({tag, " wait count"}, nw, exp_w);
        check("R2 cycle length", ns, 4 + exp_w);
        step();
        if (hold_start) begin
            check("R8 back-to-back T1", int'(state), 1);
            cyc_start = 1'b0;
            for (int i = 0; i < 40; i++) begin
                if (state == 3'd0) break;
                step();
            end
        end else begin
            check("R8 idle after T4", int'(state), 0);
        end
        ext_acc  = 1'b1;
        slow_clk = 1'b0;
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        step();
        check("R1 reset state", int'(state), 0);
        check("R1 reset wait_active", int'(wait_act), 0);
        check("R1 reset done", int'(done), 0);
        step();
        rst_n = 1'b1;
        step();
        step();
        check("R2 stays idle without start", int'(state), 0);

        run_cycle(2'b00, 1'b1, 1'b0, 0,  1'b0, 1'b0, "R3 sel00");
        run_cycle(2'b01, 1'b1, 1'b0, 4,  1'b0, 1'b0, "R3 sel01");
        run_cycle(2'b10, 1'b1, 1'b0, 8,  1'b0, 1'b0, "R3 sel10");
        run_cycle(2'b11, 1'b1, 1'b0, 12, 1'b0, 1'b0, "R3 sel11");
        run_cycle(2'b11, 1'b0, 1'b0, 0,  1'b0, 1'b0, "R5 internal");
        run_cycle(2'b11, 1'b1, 1'b1, 0,  1'b0, 1'b0, "R6 slow clock");
        run_cycle(2'b01, 1'b1, 1'b0, 4,  1'b1, 1'b0, "R7 held after T1");
        run_cycle(2'b00, 1'b0, 1'b1, 0,  1'b1, 1'b0, "R7 no late waits");
        run_cycle(2'b10, 1'b1, 1'b0, 8,  1'b0, 1'b1, "R2 start ignored mid-cycle");

        // Reset in the middle of a wait stretch.
        cyc_start = 1'b1;
        wait_sel  = 2'b11;
        step();
        cyc_start = 1'b0;
        for (int i = 0; i < 5; i++) step();
        check("R4 inside wait stretch", int'(state), 4);
        rst_n = 1'b0;
        step();
        check("R1 mid-cycle reset state", int'(state), 0);
        check("R1 mid-cycle reset wait_active", int'(wait_act), 0);
        rst_n = 1'b1;
        step();
        run_cycle(2'b01, 1'b1, 1'b0, 4, 1'b0, 1'b0, "R1 clean after reset");

        finished = 1'b1;
        report();
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            report();
            $finish;
        end
    end

endmodule